// File: doc/BRIEF.md
# Backscatter Reply Frame Encoder

This block turns a reply held in a word buffer into the modulation waveform that a passive tag sends back to a reader. A start strobe captures the frame settings. The block then sends a run of pilot symbols, a fixed six-bit preamble, the requested number of data bits and a closing dummy bit. Every bit is FM0 line-coded onto a single output pin.

Symbol timing comes from a reference clock enable, nominally 3 MHz. Each half-symbol lasts `HALF_REF` enabled cycles, which is 1 µs at 3 MHz. A slow mode, chosen at start, stretches every half-symbol by `SLOW_FACTOR` and leaves the bit sequence unchanged.

Data is fetched one 16-bit word at a time, starting at a base address. The two bytes of each word are swapped before the word is shifted out, so the low byte is sent first. Only the words the bit count needs are read. `busy_o` covers the whole frame. `done_o` pulses for one cycle when the frame ends.

Top module: `bsc_reply_encoder`

## Requirements
- R1: After reset and whenever no frame is running, `mod_o`, `busy_o`, `done_o` and `rd_req_o` are all 0.
- R2: The frame opens with pilot symbols, each carrying data value 0. There are 4 of them when `pilot_ext_i` is 0 at start and 16 when it is 1.
- R3: Right after the pilot, the bits 0,1,0,1,1,1 are sent in that order.
- R4: FM0 coding: the output inverts at the start of every bit, and the first bit of a frame drives it from low to high. A data 0 also inverts the output at mid-bit. A data 1 holds the level for the whole bit.
- R5: Each half-bit lasts `HALF_REF` cycles of `ref_en_i` when `slow_mode_i` was 0 at start, and `HALF_REF*SLOW_FACTOR` cycles when it was 1. The output never changes in a cycle that follows a low `ref_en_i` while a frame runs.
- R6: Data bits come from words at `base_addr_i`, `base_addr_i+1` and so on. Each word is sent as bits 7 down to 0, then bits 15 down to 8.
- R7: Exactly ceil(N/16) words are read for a bit count N, at consecutive addresses and only during a frame. `rd_data_i` is taken one clock after `rd_req_o`. The last word may be sent only in part.
- R8: After the last data bit, a single dummy bit of value 1 is sent.
- R9: A bit count of 0 sends the pilot, the preamble and the dummy bit, and reads no words.
- R10: `busy_o` rises on the clock edge that accepts a start and falls on the edge that ends the dummy bit. On that same edge `done_o` pulses high for one cycle and `mod_o` returns to 0.
- R11: A start strobe that arrives during a frame is ignored. The waveform and the frame length stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_en_i | input | 1 | Reference-rate clock enable for the symbol timebase |
| slow_mode_i | input | 1 | Stretch the half-symbol by SLOW_FACTOR; sampled at start |
| start_i | input | 1 | Start strobe; takes effect only when idle |
| pilot_ext_i | input | 1 | Long pilot (16 symbols) when 1; sampled at start |
| bit_count_i | input | CNT_W | Number of data bits; sampled at start |
| base_addr_i | input | ADDR_W | Word address of the first data word; sampled at start |
| rd_req_o | output | 1 | Word read strobe |
| rd_addr_o | output | ADDR_W | Word read address |
| rd_data_i | input | 16 | Read data, valid one clock after rd_req_o |
| mod_o | output | 1 | FM0 modulation output |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle pulse at frame end |

## Verification
Directed frames cover both pilot lengths with an empty payload. They also cover payloads of exactly one word, one word plus one bit, and a single bit in slow mode. These tell apart off-by-one errors at the word boundary, at the preamble-to-data handover and at the pilot count. Random frames then vary the bit count, base address, slow mode and pilot length over buffer contents drawn at random. A stray start is injected partway through some of these frames. Every half-bit is compared with a waveform built from the requirements, both at its first cycle and at its last, so a wrong duration is caught as well as a wrong level. The read count and the last address of each frame show whether the block over-reads or under-reads the buffer.

// File: rtl/brf_pkg.sv
package brf_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_PILOT,
    PH_PREAM,
    PH_DATA,
    PH_DUMMY
  } phase_e;

  localparam int WORD_W = 16;
  localparam int PREAM_LEN = 6;
  // sent from bit 5 down to bit 0
  localparam logic [PREAM_LEN-1:0] PREAM_BITS = 6'b010111;

  function automatic logic [WORD_W-1:0] swap_bytes(input logic [WORD_W-1:0] w);
    return {w[7:0], w[15:8]};
  endfunction
endpackage

// File: rtl/brf_timebase.sv
module brf_timebase #(
  parameter int HALF_REF    = 3,
  parameter int SLOW_FACTOR = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_acc_i,
  input  logic slow_i,
  input  logic run_i,
  input  logic ref_en_i,
  output logic half_tick_o
);
  localparam int LONG_REF = HALF_REF * SLOW_FACTOR;
  localparam int CW = $clog2(LONG_REF + 1);
  localparam logic [CW-1:0] LIM_FAST = CW'(HALF_REF - 1);
  localparam logic [CW-1:0] LIM_SLOW = CW'(LONG_REF - 1);

  logic          slow_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim;

  assign lim = slow_q ? LIM_SLOW : LIM_FAST;
  assign half_tick_o = run_i & ref_en_i & (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slow_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_acc_i) begin
      slow_q <= slow_i;
      cnt_q  <= '0;
    end else if (run_i && ref_en_i) begin
      cnt_q <= (cnt_q == lim) ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/brf_word_feed.sv
module brf_word_feed
  import brf_pkg::*;
#(
  parameter int CNT_W  = 12,
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_acc_i,
  input  logic [ADDR_W-1:0] base_addr_i,
  input  logic [CNT_W-1:0]  bit_count_i,
  input  logic              load_i,
  input  logic              shift_i,
  output logic              bit_o,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [WORD_W-1:0] rd_data_i
);
  localparam int WCNT_W = CNT_W - 3;

  logic [WCNT_W-1:0] words_need;
  logic [WCNT_W-1:0] words_left_q;
  logic [ADDR_W-1:0] addr_q;
  logic              fetch_q;
  logic              cap_q;
  logic [WORD_W-1:0] next_q;
  logic [WORD_W-1:0] sh_q;

  assign words_need = WCNT_W'(bit_count_i[CNT_W-1:4]) + WCNT_W'(|bit_count_i[3:0]);
  assign bit_o      = sh_q[WORD_W-1];
  assign rd_req_o   = fetch_q;
  assign rd_addr_o  = addr_q;

  // request / address side
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q       <= '0;
      words_left_q <= '0;
      fetch_q      <= 1'b0;
    end else if (start_acc_i) begin
      addr_q       <= base_addr_i;
      words_left_q <= words_need;
      fetch_q      <= (words_need != '0);
    end else if (fetch_q) begin
      addr_q       <= addr_q + 1'b1;
      words_left_q <= words_left_q - 1'b1;
      fetch_q      <= 1'b0;
    end else if (load_i) begin
      fetch_q <= (words_left_q != '0);
    end
  end

  // data side: one-word lookahead plus shifter
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_q  <= 1'b0;
      next_q <= '0;
      sh_q   <= '0;
    end else begin
      cap_q <= fetch_q;
      if (cap_q) next_q <= rd_data_i;
      if (load_i) sh_q <= swap_bytes(next_q);
      else if (shift_i) sh_q <= {sh_q[WORD_W-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/brf_fm0_line.sv
module brf_fm0_line (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_acc_i,
  input  logic half_tick_i,
  input  logic second_half_i,
  input  logic bit_i,
  input  logic last_bit_i,
  output logic mod_o
);
  logic mod_q;
  assign mod_o = mod_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mod_q <= 1'b0;
    end else if (start_acc_i) begin
      mod_q <= 1'b1;
    end else if (half_tick_i) begin
      if (second_half_i) mod_q <= last_bit_i ? 1'b0 : ~mod_q;
      else if (!bit_i)   mod_q <= ~mod_q;
    end
  end
endmodule

// File: rtl/brf_sequencer.sv
module brf_sequencer
  import brf_pkg::*;
#(
  parameter int CNT_W       = 12,
  parameter int PILOT_SHORT = 4,
  parameter int PILOT_LONG  = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             pilot_ext_i,
  input  logic [CNT_W-1:0] bit_count_i,
  input  logic             half_tick_i,
  input  logic             feed_bit_i,
  output logic             start_acc_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             second_half_o,
  output logic             bit_o,
  output logic             last_bit_o,
  output logic             load_o,
  output logic             shift_o
);
  localparam int PW = $clog2(PILOT_LONG + 1);
  localparam logic [PW-1:0] P_SHORT = PW'(PILOT_SHORT);
  localparam logic [PW-1:0] P_LONG  = PW'(PILOT_LONG);
  localparam logic [2:0] PREAM_LAST = 3'(PREAM_LEN - 1);

  phase_e          phase_q;
  logic [PW-1:0]   pilot_q;
  logic [2:0]      pidx_q;
  logic [CNT_W-1:0] left_q;
  logic [3:0]      wbit_q;
  logic            half_q;
  logic            done_q;
  logic            bit_end;
  logic            more_data;

  assign start_acc_o   = start_i & (phase_q == PH_IDLE);
  assign busy_o        = (phase_q != PH_IDLE);
  assign done_o        = done_q;
  assign second_half_o = half_q;
  assign last_bit_o    = (phase_q == PH_DUMMY);
  assign bit_end       = half_tick_i & half_q;
  assign more_data     = (left_q != CNT_W'(1));

  always_comb begin
    unique case (phase_q)
      PH_PREAM: bit_o = PREAM_BITS[3'(PREAM_LEN - 1) - pidx_q];
      PH_DATA:  bit_o = feed_bit_i;
      PH_DUMMY: bit_o = 1'b1;
      default:  bit_o = 1'b0;
    endcase
  end

  assign load_o  = bit_end &
                   (((phase_q == PH_PREAM) && (pidx_q == PREAM_LAST) && (left_q != '0)) ||
                    ((phase_q == PH_DATA) && more_data && (wbit_q == 4'd15)));
  assign shift_o = bit_end & (phase_q == PH_DATA) & more_data & (wbit_q != 4'd15);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      pilot_q <= '0;
      pidx_q  <= '0;
      left_q  <= '0;
      wbit_q  <= '0;
      half_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_acc_o) begin
        phase_q <= PH_PILOT;
        pilot_q <= pilot_ext_i ? P_LONG : P_SHORT;
        pidx_q  <= '0;
        left_q  <= bit_count_i;
        wbit_q  <= '0;
        half_q  <= 1'b0;
      end else if (half_tick_i) begin
        half_q <= ~half_q;
        if (half_q) begin
          unique case (phase_q)
            PH_PILOT: begin
              if (pilot_q == PW'(1)) phase_q <= PH_PREAM;
              pilot_q <= pilot_q - 1'b1;
            end
            PH_PREAM: begin
              if (pidx_q == PREAM_LAST) phase_q <= (left_q == '0) ? PH_DUMMY : PH_DATA;
              pidx_q <= pidx_q + 1'b1;
            end
            PH_DATA: begin
              if (!more_data) phase_q <= PH_DUMMY;
              left_q <= left_q - 1'b1;
              wbit_q <= wbit_q + 1'b1;
            end
            PH_DUMMY: begin
              phase_q <= PH_IDLE;
              done_q  <= 1'b1;
            end
            default: phase_q <= PH_IDLE;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/bsc_reply_encoder.sv
module bsc_reply_encoder
  import brf_pkg::*;
#(
  parameter int CNT_W       = 12,
  parameter int ADDR_W      = 8,
  parameter int HALF_REF    = 3,
  parameter int SLOW_FACTOR = 4,
  parameter int PILOT_SHORT = 4,
  parameter int PILOT_LONG  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ref_en_i,
  input  logic              slow_mode_i,
  input  logic              start_i,
  input  logic              pilot_ext_i,
  input  logic [CNT_W-1:0]  bit_count_i,
  input  logic [ADDR_W-1:0] base_addr_i,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [WORD_W-1:0] rd_data_i,
  output logic              mod_o,
  output logic              busy_o,
  output logic              done_o
);
  logic start_acc, half_tick, second_half, cur_bit, last_bit, feed_bit, load, shift;

  brf_sequencer #(
    .CNT_W(CNT_W), .PILOT_SHORT(PILOT_SHORT), .PILOT_LONG(PILOT_LONG)
  ) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .pilot_ext_i(pilot_ext_i),
    .bit_count_i(bit_count_i), .half_tick_i(half_tick), .feed_bit_i(feed_bit),
    .start_acc_o(start_acc), .busy_o(busy_o), .done_o(done_o),
    .second_half_o(second_half), .bit_o(cur_bit), .last_bit_o(last_bit),
    .load_o(load), .shift_o(shift)
  );

  brf_timebase #(.HALF_REF(HALF_REF), .SLOW_FACTOR(SLOW_FACTOR)) u_tb (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_acc_i(start_acc), .slow_i(slow_mode_i),
    .run_i(busy_o), .ref_en_i(ref_en_i), .half_tick_o(half_tick)
  );

  brf_word_feed #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_feed (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_acc_i(start_acc), .base_addr_i(base_addr_i),
    .bit_count_i(bit_count_i), .load_i(load), .shift_i(shift), .bit_o(feed_bit),
    .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .rd_data_i(rd_data_i)
  );

  brf_fm0_line u_line (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_acc_i(start_acc), .half_tick_i(half_tick),
    .second_half_i(second_half), .bit_i(cur_bit), .last_bit_i(last_bit), .mod_o(mod_o)
  );
endmodule

// File: rtl/bsc_reply_encoder_chk.sv
module bsc_reply_encoder_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic ref_en_i,
  input logic start_i,
  input logic rd_req_o,
  input logic mod_o,
  input logic busy_o,
  input logic done_o
);
  assert_idle_low_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mod_o);

  assert_hold_no_enable_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o) && !$past(ref_en_i)) |-> $stable(mod_o));

  assert_read_in_frame_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |-> busy_o);

  assert_done_at_end_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));

  assert_done_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_start_ignored_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> (busy_o || done_o));
endmodule

bind bsc_reply_encoder bsc_reply_encoder_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ref_en_i(ref_en_i), .start_i(start_i),
  .rd_req_o(rd_req_o), .mod_o(mod_o), .busy_o(busy_o), .done_o(done_o)
);

// File: tb/tb_bsc_reply_encoder.sv
module tb_bsc_reply_encoder;
  localparam int CNT_W = 12, ADDR_W = 8, HALF = 3, SLOWF = 4;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic ref_en_i = 1'b1, slow_mode_i = 1'b0, start_i = 1'b0, pilot_ext_i = 1'b0;
  logic [CNT_W-1:0] bit_count_i = '0;
  logic [ADDR_W-1:0] base_addr_i = '0;
  logic rd_req_o, mod_o, busy_o, done_o;
  logic [ADDR_W-1:0] rd_addr_o;
  logic [15:0] rd_data_i = '0;
  logic [15:0] mem [0:255];
  int rd_total = 0;
  int last_addr = 0;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  bsc_reply_encoder #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .HALF_REF(HALF), .SLOW_FACTOR(SLOWF)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .ref_en_i(ref_en_i), .slow_mode_i(slow_mode_i),
    .start_i(start_i), .pilot_ext_i(pilot_ext_i), .bit_count_i(bit_count_i),
    .base_addr_i(base_addr_i), .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o),
    .rd_data_i(rd_data_i), .mod_o(mod_o), .busy_o(busy_o), .done_o(done_o)
  );

  // synchronous buffer: data one clock after the request
  always @(posedge clk) begin
    if (rd_req_o) begin
      rd_data_i <= mem[rd_addr_o];
      rd_total  <= rd_total + 1;
      last_addr <= int'(rd_addr_o);
    end
  end

  task automatic chk(input string tag, input int act, input int exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic string sect(input int b, input int p, input int n);
    if (b < p) return "R2";
    if (b < p + 6) return "R3";
    if (b < p + 6 + n) return "R6";
    return "R8";
  endfunction

  task automatic run_frame(input bit pext, input int n, input int base, input bit slow, input bit inject);
    int L = slow ? HALF * SLOWF : HALF;
    int p = pext ? 16 : 4;
    int nb = p + 6 + n + 1;
    int words = (n + 15) / 16;
    int rd0;
    bit bits [0:255];
    bit halves [0:511];
    bit lvl = 1'b0;
    logic [5:0] pre = 6'b010111;
    for (int b = 0; b < p; b++) bits[b] = 1'b0;
    for (int b = 0; b < 6; b++) bits[p + b] = pre[5 - b];
    for (int i = 0; i < n; i++) begin
      logic [15:0] w = mem[base + i / 16];
      logic [15:0] s = {w[7:0], w[15:8]};
      bits[p + 6 + i] = s[15 - (i % 16)];
    end
    bits[nb - 1] = 1'b1;
    for (int b = 0; b < nb; b++) begin
      lvl = ~lvl;
      halves[2 * b] = lvl;
      if (!bits[b]) lvl = ~lvl;
      halves[2 * b + 1] = lvl;
    end
    @(negedge clk);
    rd0 = rd_total;
    pilot_ext_i = pext; bit_count_i = CNT_W'(n); base_addr_i = ADDR_W'(base);
    slow_mode_i = slow; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk("R4", int'(mod_o), 1, "first half of frame");
    for (int c = 0; c < 2 * nb * L; c++) begin
      int h = c / L;
      if (c % L == 0) begin
        chk(sect(h / 2, p, n), int'(mod_o), int'(halves[h]), $sformatf("half %0d level", h));
        chk("R10", int'(busy_o), 1, "busy in frame");
      end
      if (c % L == L - 1) chk("R5", int'(mod_o), int'(halves[h]), $sformatf("half %0d end level", h));
      if (inject && c == 5 * L) begin
        start_i = 1'b1; pilot_ext_i = ~pext; bit_count_i = CNT_W'(3);
      end else begin
        start_i = 1'b0;
      end
      @(negedge clk);
    end
    chk(inject ? "R11" : "R10", int'(done_o), 1, "done at frame end");
    chk("R10", int'(busy_o), 0, "busy after frame");
    chk("R10", int'(mod_o), 0, "mod after frame");
    chk("R7", rd_total - rd0, words, "words read");
    if (words > 0) chk("R7", last_addr, base + words - 1, "last address");
    else chk("R9", rd_total - rd0, 0, "no reads for empty payload");
    @(negedge clk);
    chk("R10", int'(done_o), 0, "done one cycle");
    chk("R1", int'(rd_req_o), 0, "no read when idle");
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL R10 watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h0000_5eed));
    for (int i = 0; i < 256; i++) mem[i] = 16'($urandom);
    repeat (3) @(negedge clk);
    chk("R1", int'(mod_o), 0, "reset mod");
    chk("R1", int'(busy_o), 0, "reset busy");
    chk("R1", int'(done_o), 0, "reset done");
    chk("R1", int'(rd_req_o), 0, "reset read");
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", int'(mod_o), 0, "idle mod");
    // directed corners
    run_frame(1'b0, 0, 5, 1'b0, 1'b0);    // R9 short pilot
    run_frame(1'b1, 0, 5, 1'b0, 1'b0);    // R9 long pilot
    run_frame(1'b0, 16, 10, 1'b0, 1'b0);  // R7 exact word
    run_frame(1'b1, 17, 20, 1'b0, 1'b0);  // R7 one bit into second word
    run_frame(1'b0, 1, 30, 1'b1, 1'b0);   // R5 slow mode
    run_frame(1'b0, 33, 40, 1'b0, 1'b1);  // R11 stray start
    for (int k = 0; k < 14; k++) begin
      run_frame(1'($urandom), int'($urandom_range(0, 100)), int'($urandom_range(0, 150)),
                ($urandom % 4) == 0, ($urandom % 3) == 0);
      repeat (int'($urandom_range(0, 4))) @(negedge clk);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule